// File: doc/BRIEF.md
# Pulse Strip-and-Forward Node

This block sits in a chain of identical processing nodes. Each node receives a sample stream in which several fixed-length pulses follow one another without gaps in the sequence, with a marker on the first sample of the burst. The node keeps the leading pulse for its own local processing port. It passes every later sample on to the next node without change. The node marks the first forwarded sample as the start of a new burst, so the next node in the chain takes the following pulse in the same way. With four nodes in series, a burst of four pulses is split with one pulse per node.

The samples are complex, with a signed real part and a signed imaginary part of up to 8 bits each. The node accepts one sample per clock and applies no backpressure. Both output streams are registered and appear exactly one clock after the input sample. The pulse length is chosen with a two-bit code from three sizes: the base length, twice the base and four times the base. With the default base of 16384 these are 16K, 32K and 64K samples. The node reads the code only when a burst starts.

If a new burst marker arrives before the local pulse is complete, the node flags a short pulse. It then starts capturing again from the new burst.

Top module: `psf_node`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `loc_valid`, `loc_sop`, `loc_eop`, `dn_valid`, `dn_start` and `short_err` are all 0.
- R2: The pulse length L is set by `len_sel`: code 0 gives BASE_LEN, code 1 gives 2*BASE_LEN, code 2 gives 4*BASE_LEN, and code 3 is treated as code 2.
- R3: The valid sample that carries `in_start` and the next L-1 valid samples appear on the local port (`loc_valid`=1) with unchanged real and imaginary parts, one clock after they enter.
- R4: `loc_sop` is 1 only with the first local sample of a pulse. `loc_eop` is 1 only with the L-th local sample.
- R5: After the L-th sample, every further valid sample without `in_start` appears unchanged on the downstream port (`dn_valid`=1) one clock after it enters.
- R6: `dn_start` is 1 with the first downstream sample of each burst and 0 with every later one.
- R7: Valid samples that arrive after reset and before the first `in_start` are dropped: neither valid output is set for them.
- R8: A cycle with `in_valid`=0 produces no output one clock later and does not advance the sample count.
- R9: An `in_start` that arrives while the local pulse is still incomplete sets `short_err` for exactly one cycle, aligned with the `loc_sop` of the new pulse. Counting restarts from that sample.
- R10: An `in_start` that arrives while the node is forwarding begins a new local pulse and does not set `short_err`.
- R11: `len_sel` is sampled only on a valid `in_start` sample. Changing it in the middle of a pulse does not move `loc_eop`.
- R12: `loc_valid` and `dn_valid` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_sel | input | 2 | Pulse length code, read at burst start |
| in_valid | input | 1 | Input sample qualifier |
| in_start | input | 1 | First sample of a burst |
| in_re | input | DATA_W | Input real part |
| in_im | input | DATA_W | Input imaginary part |
| loc_valid | output | 1 | Local port sample valid |
| loc_sop | output | 1 | First sample of the local pulse |
| loc_eop | output | 1 | Last sample of the local pulse |
| loc_re | output | DATA_W | Local real part |
| loc_im | output | DATA_W | Local imaginary part |
| dn_valid | output | 1 | Downstream sample valid |
| dn_start | output | 1 | Regenerated burst start for the next node |
| dn_re | output | DATA_W | Downstream real part |
| dn_im | output | DATA_W | Downstream imaginary part |
| short_err | output | 1 | Burst restarted before the local pulse completed |

## Verification
Every result appears exactly one clock after the sample that causes it. This holds for the local and downstream valids, the markers, the data and the short-pulse flag. The bench applies each sample half a clock before a rising edge. It samples the outputs just after that edge and compares them with the values it expects for that same sample. An idle cycle is checked in the same way: the cycle after it must show no output. The end marker is expected on the L-th valid sample, counting only valid samples, and this is checked with gaps, with mid-pulse changes of the length code and for every code.

// File: rtl/psf_pkg.sv
package psf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAP  = 2'd1,
        ST_FWD  = 2'd2
    } psf_state_e;

    typedef struct packed {
        logic loc;
        logic sop;
        logic eop;
        logic dn;
        logic dn_first;
        logic err;
    } psf_route_t;
endpackage

// File: rtl/psf_len_dec.sv
module psf_len_dec #(
    parameter int BASE_LEN = 16384,
    parameter int LEN_W    = $clog2(4*BASE_LEN+1)
) (
    input  logic [1:0]       sel,
    output logic [LEN_W-1:0] len
);
    localparam logic [LEN_W-1:0] L1 = LEN_W'(BASE_LEN);
    localparam logic [LEN_W-1:0] L2 = LEN_W'(2*BASE_LEN);
    localparam logic [LEN_W-1:0] L4 = LEN_W'(4*BASE_LEN);

    always_comb begin
        unique case (sel)
            2'd0:    len = L1;
            2'd1:    len = L2;
            default: len = L4;
        endcase
    end
endmodule

// File: rtl/psf_ctrl.sv
module psf_ctrl
    import psf_pkg::*;
#(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic [LEN_W-1:0] len_in,
    output psf_route_t       route
);
    typedef struct packed {
        psf_state_e       st;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic             first;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        route = '0;
        if (in_valid) begin
            if (in_start) begin
                route.err = (s_q.st == ST_CAP);
                route.loc = 1'b1;
                route.sop = 1'b1;
                route.eop = (len_in == LEN_W'(1));
                s_d.len   = len_in;
                s_d.cnt   = LEN_W'(1);
                s_d.first = 1'b1;
                s_d.st    = route.eop ? ST_FWD : ST_CAP;
            end else begin
                unique case (s_q.st)
                    ST_CAP: begin
                        route.loc = 1'b1;
                        route.eop = (s_q.cnt == s_q.len - LEN_W'(1));
                        s_d.cnt   = s_q.cnt + LEN_W'(1);
                        if (route.eop) s_d.st = ST_FWD;
                    end
                    ST_FWD: begin
                        route.dn       = 1'b1;
                        route.dn_first = s_q.first;
                        s_d.first      = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.cnt   <= '0;
            s_q.len   <= '0;
            s_q.first <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R4
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_CAP) |-> (s_q.cnt < s_q.len && s_q.cnt != '0));

    // R8
    hold_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(s_q));
endmodule

// File: rtl/psf_out_stage.sv
module psf_out_stage
    import psf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  psf_route_t        route,
    input  logic [DATA_W-1:0] in_re,
    input  logic [DATA_W-1:0] in_im,
    output logic              loc_valid,
    output logic              loc_sop,
    output logic              loc_eop,
    output logic              dn_valid,
    output logic              dn_start,
    output logic              short_err,
    output logic [DATA_W-1:0] out_re,
    output logic [DATA_W-1:0] out_im
);
    typedef struct packed {
        psf_route_t        r;
        logic [DATA_W-1:0] re;
        logic [DATA_W-1:0] im;
    } oreg_t;

    oreg_t o_d, o_q;

    always_comb begin
        o_d    = o_q;
        o_d.r  = route;
        if (route.loc || route.dn) begin
            o_d.re = in_re;
            o_d.im = in_im;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign loc_valid = o_q.r.loc;
    assign loc_sop   = o_q.r.sop;
    assign loc_eop   = o_q.r.eop;
    assign dn_valid  = o_q.r.dn;
    assign dn_start  = o_q.r.dn_first;
    assign short_err = o_q.r.err;
    assign out_re    = o_q.re;
    assign out_im    = o_q.im;
endmodule

// File: rtl/psf_node.sv
module psf_node
    import psf_pkg::*;
#(
    parameter int BASE_LEN = 16384,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        len_sel,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic [DATA_W-1:0] in_re,
    input  logic [DATA_W-1:0] in_im,
    output logic              loc_valid,
    output logic              loc_sop,
    output logic              loc_eop,
    output logic [DATA_W-1:0] loc_re,
    output logic [DATA_W-1:0] loc_im,
    output logic              dn_valid,
    output logic              dn_start,
    output logic [DATA_W-1:0] dn_re,
    output logic [DATA_W-1:0] dn_im,
    output logic              short_err
);
    localparam int LEN_W = $clog2(4*BASE_LEN+1);

    logic [LEN_W-1:0]  len_w;
    psf_route_t        route_w;
    logic [DATA_W-1:0] out_re_w, out_im_w;

    psf_len_dec #(.BASE_LEN(BASE_LEN), .LEN_W(LEN_W)) u_len (
        .sel (len_sel),
        .len (len_w)
    );

    psf_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_start (in_start),
        .len_in   (len_w),
        .route    (route_w)
    );

    psf_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .route     (route_w),
        .in_re     (in_re),
        .in_im     (in_im),
        .loc_valid (loc_valid),
        .loc_sop   (loc_sop),
        .loc_eop   (loc_eop),
        .dn_valid  (dn_valid),
        .dn_start  (dn_start),
        .short_err (short_err),
        .out_re    (out_re_w),
        .out_im    (out_im_w)
    );

    assign loc_re = out_re_w;
    assign loc_im = out_im_w;
    assign dn_re  = out_re_w;
    assign dn_im  = out_im_w;

    // R12
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_valid && dn_valid));

    // R4
    marks_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_sop || loc_eop) |-> loc_valid);

    // R6
    dn_start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_start |-> dn_valid);

    // R9
    err_with_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_err |-> loc_sop);

    // R3
    loc_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_start |=> loc_valid && loc_re == $past(in_re) && loc_im == $past(in_im));

    // R8
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !loc_valid && !dn_valid);
endmodule

// File: tb/psf_node_tb.sv
module psf_node_tb;
    localparam int BASE = 4;
    localparam int DW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    len_sel = 2'd0;
    logic          in_valid = 1'b0, in_start = 1'b0;
    logic [DW-1:0] in_re = '0, in_im = '0;
    logic          loc_valid, loc_sop, loc_eop, dn_valid, dn_start, short_err;
    logic [DW-1:0] loc_re, loc_im, dn_re, dn_im;

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] seed = 8'd1;

    always #5 clk = ~clk;

    psf_node #(.BASE_LEN(BASE), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .len_sel(len_sel),
        .in_valid(in_valid), .in_start(in_start), .in_re(in_re), .in_im(in_im),
        .loc_valid(loc_valid), .loc_sop(loc_sop), .loc_eop(loc_eop),
        .loc_re(loc_re), .loc_im(loc_im),
        .dn_valid(dn_valid), .dn_start(dn_start), .dn_re(dn_re), .dn_im(dn_im),
        .short_err(short_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive one cycle; outputs for it are sampled 1 ns after the next edge
    task automatic step(input logic v, input logic s);
        @(negedge clk);
        in_valid = v; in_start = s;
        in_re = seed; in_im = ~seed;
        @(posedge clk); #1;
        check("R12", "both valids", int'(loc_valid && dn_valid), 0);
    endtask

    task automatic exp_loc(input string req, input logic sop, input logic eop, input logic err);
        check(req, "loc_valid", loc_valid, 1);
        check(req, "loc_sop", loc_sop, sop);
        check(req, "loc_eop", loc_eop, eop);
        check(req, "short_err", short_err, err);
        check(req, "loc_re", loc_re, seed);
        check(req, "loc_im", loc_im, 8'(~seed));
        seed = seed + 8'd3;
    endtask

    task automatic exp_dn(input string req, input logic st);
        check(req, "dn_valid", dn_valid, 1);
        check(req, "loc_valid", loc_valid, 0);
        check(req, "dn_start", dn_start, st);
        check(req, "dn_re", dn_re, seed);
        check(req, "dn_im", dn_im, 8'(~seed));
        seed = seed + 8'd3;
    endtask

    task automatic exp_none(input string req);
        check(req, "loc_valid", loc_valid, 0);
        check(req, "dn_valid", dn_valid, 0);
        check(req, "short_err", short_err, 0);
    endtask

    function automatic int len_of(input int sel);
        return (sel == 0) ? BASE : (sel == 1) ? 2*BASE : 4*BASE;
    endfunction

    task automatic t_reset();
        check("R1", "loc_valid", loc_valid, 0);
        check("R1", "dn_valid", dn_valid, 0);
        check("R1", "markers", int'({loc_sop, loc_eop, dn_start, short_err}), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", "post-reset outputs", int'({loc_valid, dn_valid, short_err}), 0);
    endtask

    task automatic t_idle_drop();
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0); exp_none("R7"); seed = seed + 8'd1;
        end
    endtask

    // a full burst: local pulse then nfwd forwarded samples; gaps optional
    task automatic t_burst(input int sel, input int nfwd, input bit gaps, input string req);
        int l = len_of(sel);
        len_sel = 2'(sel);
        for (int i = 0; i < l; i++) begin
            step(1'b1, i == 0);
            if (i == 1) len_sel = 2'(sel ^ 1);  // R11 mid-pulse change
            exp_loc(req, i == 0, i == l-1, 1'b0);
            if (gaps && (i % 2 == 0)) begin step(1'b0, 1'b0); exp_none("R8"); end
        end
        for (int j = 0; j < nfwd; j++) begin
            step(1'b1, 1'b0); exp_dn("R6", j == 0);
            if (gaps) begin step(1'b0, 1'b0); exp_none("R8"); end
        end
    endtask

    task automatic t_short();
        len_sel = 2'd1;
        step(1'b1, 1'b1); exp_loc("R9", 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0); exp_loc("R9", 1'b0, 1'b0, 1'b0);
        len_sel = 2'd0;
        step(1'b1, 1'b1); exp_loc("R9", 1'b1, 1'b0, 1'b1);
        for (int i = 1; i < BASE; i++) begin
            step(1'b1, 1'b0); exp_loc("R9", 1'b0, i == BASE-1, 1'b0);
        end
        step(1'b1, 1'b0); exp_dn("R9", 1'b1);
    endtask

    task automatic t_restart_fwd();
        t_burst(0, 2, 1'b0, "R5");
        len_sel = 2'd0;
        step(1'b1, 1'b1); exp_loc("R10", 1'b1, 1'b0, 1'b0);
        for (int i = 1; i < BASE; i++) begin
            step(1'b1, 1'b0); exp_loc("R10", 1'b0, i == BASE-1, 1'b0);
        end
        step(1'b1, 1'b0); exp_dn("R10", 1'b1);
    endtask

    initial begin
        #(20000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_idle_drop();
        t_burst(0, 3, 1'b0, "R3");   // R2 code 0, R4 marks
        t_burst(1, 2, 1'b0, "R4");   // R2 code 1, R11 mid change
        t_burst(2, 2, 1'b0, "R2");   // code 2
        t_burst(3, 1, 1'b0, "R2");   // code 3 acts as code 2
        t_burst(0, 5, 1'b0, "R5");
        t_burst(1, 2, 1'b1, "R8");   // gaps do not advance count
        t_burst(2, 1, 1'b0, "R11");
        t_short();
        t_restart_fwd();
        step(1'b0, 1'b0); exp_none("R8");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule